// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

The block caches recent page-number to frame-number translations. A lookup presents a virtual page number and a page offset. That page number is compared with every stored key in the same cycle. On a hit the block returns the physical address, formed as the frame number followed by the offset, together with the entry's permission bits. On a miss it raises a miss flag, and no address is produced.

An external page-table walker answers misses through the fill port. Each fill installs one pair. When the page is already resident, the fill updates the existing entry in place. When the page is new, it goes into a free slot if one exists, and otherwise over a victim chosen by a rotating pointer. A flush input empties the whole buffer on a context switch.

Permissions are three bits: bit 0 read, bit 1 write, bit 2 execute. Only the write bit is enforced. A write request that hits a page without write permission reports a fault instead of a hit.

Top module: `xlat_buf`

## Requirements
- R1: When `lk_valid_i` is high and a valid entry holds `lk_vpn_i`, then in the same cycle `lk_hit_o`=1 and `lk_miss_o`=0. `lk_paddr_o` equals {frame, `lk_off_i`} and `lk_perm_o` equals the entry's permissions. This holds unless R8 applies.
- R2: When `lk_valid_i` is high and no valid entry matches, then `lk_miss_o`=1 and `lk_hit_o`=`lk_fault_o`=0. `lk_paddr_o` and `lk_perm_o` are 0.
- R3: When `lk_valid_i` is low, `lk_hit_o`, `lk_miss_o` and `lk_fault_o` are 0, and `lk_paddr_o` and `lk_perm_o` are 0.
- R4: A fill accepted at a clock edge is visible to lookups from the next cycle on. A lookup in the same cycle as the fill sees the old contents.
- R5: A fill whose page number is already resident overwrites that entry's frame and permissions. It creates no second entry and does not move the replacement pointer.
- R6: A fill of a new page goes into the lowest-indexed invalid entry when one exists. The pointer stays unchanged.
- R7: When all DEPTH entries are valid, a fill of a new page replaces the entry at the round-robin pointer. The pointer then advances by one, wrapping from DEPTH-1 to 0.
- R8: A lookup with `lk_write_i`=1 that matches an entry whose permission bit 1 is 0 gives `lk_fault_o`=1 with `lk_hit_o`=`lk_miss_o`=0. `lk_paddr_o` and `lk_perm_o` are 0. A write lookup that matches an entry with bit 1 set is a normal hit.
- R9: `flush_i` invalidates every entry and sets the pointer to 0 at the next edge. From the next cycle on, every lookup misses.
- R10: A fill in the same cycle as `flush_i` is discarded.
- R11: After reset all entries are invalid and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_off_i | input | OFF_W | Page offset |
| lk_write_i | input | 1 | Lookup is a write access |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No translation resident |
| lk_fault_o | output | 1 | Write to a page without write permission |
| lk_paddr_o | output | PFN_W+OFF_W | Physical address, valid on hit |
| lk_perm_o | output | 3 | Permissions of the hit entry {x,w,r} |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | VPN_W | Page number to install |
| fill_pfn_i | input | PFN_W | Frame number to install |
| fill_perm_i | input | 3 | Permissions to install |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The bench fills the buffer to capacity and then forces evictions in sequence. A design whose pointer starts at the wrong slot, fails to wrap, or advances on an update or a free-slot fill would evict a page that should have stayed resident. A duplicate fill is followed by a lookup and by further evictions, which exposes a design that creates a second copy of the page or loses the update. A read-only page is written to see whether the design leaks a hit or an address in place of the fault. A fill issued together with a flush is probed afterwards: a design that lets the fill win would still hit on that page. Long random traffic over a small page range also mixes same-cycle fills and lookups, which catches a fill that bypasses into the lookup of its own cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned PERM_W  = 3;
  localparam int unsigned PERM_WR = 1;  // write-permission bit
  typedef logic [PERM_W-1:0] perm_t;
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PFN_W-1:0] wr_pfn_i,
  input  perm_t            wr_perm_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             valid_o,
  output logic             lk_match_o,
  output logic             fill_match_o,
  output logic [PFN_W-1:0] pfn_o,
  output perm_t            perm_o
);
  logic [VPN_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      key_q   <= '0;
      pfn_o   <= '0;
      perm_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end else if (wr_i) begin
      valid_o <= 1'b1;
      key_q   <= wr_vpn_i;
      pfn_o   <= wr_pfn_i;
      perm_o  <= wr_perm_i;
    end
  end

  assign lk_match_o   = valid_o && (key_q == lk_vpn_i);
  assign fill_match_o = valid_o && (key_q == wr_vpn_i);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             alloc_i,   // new-page fill accepted
  input  logic [DEPTH-1:0] valid_i,
  output logic [DEPTH-1:0] sel_o
);
  logic [IDX_W-1:0] ptr_q;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    sel_o = '0;
    if (full) begin
      sel_o[ptr_q] = 1'b1;
    end else begin
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (!valid_i[i]) sel_o = DEPTH'(1) << i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (flush_i)         ptr_q <= '0;
    else if (alloc_i && full) ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 20,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned PA_W = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [OFF_W-1:0] lk_off_i,
  input  logic             lk_write_i,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic             lk_fault_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  output logic [2:0]       lk_perm_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic [2:0]       fill_perm_i,
  input  logic             flush_i
);
  logic [DEPTH-1:0] valid, lk_match, fill_match, victim_sel, wr_en;
  logic [PFN_W-1:0] ent_pfn  [DEPTH];
  perm_t            ent_perm [DEPTH];
  logic             fill_ok, fill_dup;
  logic             any_match;
  logic [PFN_W-1:0] sel_pfn;
  perm_t            sel_perm;

  assign fill_ok  = fill_valid_i && !flush_i;
  assign fill_dup = |fill_match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign wr_en[g] = fill_ok && (fill_dup ? fill_match[g] : victim_sel[g]);
    xlat_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W)) i_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (flush_i),
      .wr_i        (wr_en[g]),
      .wr_vpn_i    (fill_vpn_i),
      .wr_pfn_i    (fill_pfn_i),
      .wr_perm_i   (fill_perm_i),
      .lk_vpn_i    (lk_vpn_i),
      .valid_o     (valid[g]),
      .lk_match_o  (lk_match[g]),
      .fill_match_o(fill_match[g]),
      .pfn_o       (ent_pfn[g]),
      .perm_o      (ent_perm[g])
    );
  end

  xlat_victim #(.DEPTH(DEPTH)) i_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush_i),
    .alloc_i(fill_ok && !fill_dup),
    .valid_i(valid),
    .sel_o  (victim_sel)
  );

  // keys are unique, so an OR of masked entries is the mux
  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < DEPTH; i++) begin
      sel_pfn  |= ent_pfn[i]  & {PFN_W{lk_match[i]}};
      sel_perm |= ent_perm[i] & {PERM_W{lk_match[i]}};
    end
  end

  assign any_match  = |lk_match;
  assign lk_fault_o = lk_valid_i && any_match && lk_write_i && !sel_perm[PERM_WR];
  assign lk_hit_o   = lk_valid_i && any_match && !lk_fault_o;
  assign lk_miss_o  = lk_valid_i && !any_match;
  assign lk_paddr_o = lk_hit_o ? {sel_pfn, lk_off_i} : '0;
  assign lk_perm_o  = lk_hit_o ? sel_perm : '0;
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 20,
  parameter int unsigned OFF_W = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lk_valid_i,
  input logic [VPN_W-1:0]       lk_vpn_i,
  input logic [OFF_W-1:0]       lk_off_i,
  input logic                   lk_write_i,
  input logic                   lk_hit_o,
  input logic                   lk_miss_o,
  input logic                   lk_fault_o,
  input logic [PFN_W+OFF_W-1:0] lk_paddr_o,
  input logic                   fill_valid_i,
  input logic [VPN_W-1:0]       fill_vpn_i,
  input logic [PFN_W-1:0]       fill_pfn_i,
  input logic                   flush_i,
  input logic [DEPTH-1:0]       lk_match
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lk_hit_o, lk_miss_o, lk_fault_o})); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_fault_o)); // R3
  AST_NO_ADDR_OFF_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_paddr_o == '0); // R2
  AST_FAULT_IS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_write_i); // R8
  AST_FILL_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) |=>
      (!(lk_valid_i && !lk_write_i && lk_vpn_i == $past(fill_vpn_i)) ||
       (lk_hit_o && lk_paddr_o == {$past(fill_pfn_i), lk_off_i}))); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o && !lk_fault_o); // R9
  AST_UNIQUE_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match)); // R5
endmodule

bind xlat_buf xlat_buf_chk #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_valid_i  (lk_valid_i),
  .lk_vpn_i    (lk_vpn_i),
  .lk_off_i    (lk_off_i),
  .lk_write_i  (lk_write_i),
  .lk_hit_o    (lk_hit_o),
  .lk_miss_o   (lk_miss_o),
  .lk_fault_o  (lk_fault_o),
  .lk_paddr_o  (lk_paddr_o),
  .fill_valid_i(fill_valid_i),
  .fill_vpn_i  (fill_vpn_i),
  .fill_pfn_i  (fill_pfn_i),
  .flush_i     (flush_i),
  .lk_match    (lk_match)
);

// File: tb/test_xlat_buf.sv
module test_xlat_buf;
  localparam int DEPTH = 16, VPN_W = 20, PFN_W = 20, OFF_W = 12, PA_W = PFN_W + OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0, fill_valid = 0, flush = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [OFF_W-1:0] lk_off = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [2:0] fill_perm = '0, lk_perm;
  logic lk_hit, lk_miss, lk_fault;
  logic [PA_W-1:0] lk_paddr;

  always #2 clk = ~clk;

  xlat_buf #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) i_xlat_buf (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_off_i(lk_off), .lk_write_i(lk_write),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_fault_o(lk_fault),
    .lk_paddr_o(lk_paddr), .lk_perm_o(lk_perm),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
    .fill_perm_i(fill_perm), .flush_i(flush));

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  bit m_vld [DEPTH];
  int m_vpn [DEPTH];
  int m_pfn [DEPTH];
  int m_perm[DEPTH];
  int m_ptr = 0;

  function automatic int find(int vpn);
    for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic model_check();
    int k;
    bit eh, em, ef;
    logic [PA_W-1:0] ea;
    logic [2:0] ep;
    string tag;
    k = find(int'(lk_vpn));
    eh = 0; em = 0; ef = 0; ea = '0; ep = '0;
    if (!lk_valid) tag = "R3";
    else if (k < 0) begin em = 1; tag = "R2"; end
    else if (lk_write && !m_perm[k][1]) begin ef = 1; tag = "R8"; end
    else begin
      eh = 1; tag = "R1";
      ea = {PFN_W'(m_pfn[k]), lk_off};
      ep = 3'(m_perm[k]);
    end
    total++;
    if ({lk_hit, lk_miss, lk_fault} != {eh, em, ef} || lk_paddr != ea || lk_perm != ep) begin
      bad++;
      $display("FAIL %s: hit/miss/fault=%b%b%b paddr=%h perm=%b, expected %b%b%b %h %b",
               tag, lk_hit, lk_miss, lk_fault, lk_paddr, lk_perm, eh, em, ef, ea, ep);
    end
  endtask

  task automatic advance();
    int k;
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
      m_ptr = 0;
    end else if (fill_valid) begin
      k = find(int'(fill_vpn));
      if (k < 0) for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) k = i;
      if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % DEPTH; end
      m_vld[k] = 1; m_vpn[k] = int'(fill_vpn); m_pfn[k] = int'(fill_pfn); m_perm[k] = int'(fill_perm);
    end
    @(negedge clk);
  endtask

  task automatic fill(int vpn, int pfn, int perm, bit fl = 0);
    lk_valid = 0; fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_pfn = PFN_W'(pfn);
    fill_perm = 3'(perm); flush = fl;
    #1 model_check();
    advance();
    fill_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    lk_valid = 0; fill_valid = 0; flush = 1;
    #1 model_check();
    advance();
    flush = 0;
  endtask

  // lookup with a hand-computed expectation; exp 0=miss 1=hit 2=fault
  task automatic probe(string tag, int vpn, bit wr, int exp, int pfn);
    logic [PA_W-1:0] ea;
    lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_write = wr;
    lk_off = OFF_W'($urandom_range(0, (1 << OFF_W) - 1));
    fill_valid = 0; flush = 0;
    #1 model_check();
    ea = (exp == 1) ? {PFN_W'(pfn), lk_off} : '0;
    total++;
    if (lk_hit != (exp == 1) || lk_miss != (exp == 0) || lk_fault != (exp == 2) || lk_paddr != ea) begin
      bad++;
      $display("FAIL %s: vpn=%h hit/miss/fault=%b%b%b paddr=%h, expected outcome %0d paddr=%h",
               tag, vpn, lk_hit, lk_miss, lk_fault, lk_paddr, exp, ea);
    end
    advance();
    lk_valid = 0; lk_write = 0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    #1;
    lk_valid = 1; lk_vpn = 20'h5;
    #1;
    total++;  // R11: empty during reset
    if (!lk_miss || lk_hit) begin
      bad++; $display("FAIL R11: in reset hit=%b miss=%b, expected 0 1", lk_hit, lk_miss);
    end
    lk_valid = 0;
    #8 rst_n = 1;
    @(negedge clk);
    probe("R11", 'h5, 0, 0, 0);

    // R6: free slots taken, nothing evicted while filling to capacity; slot 3 read-only
    for (int i = 0; i < DEPTH; i++) fill('h100 + i, 'h200 + i, (i == 3) ? 3'b001 : 3'b011);
    for (int i = 0; i < DEPTH; i++) probe("R6", 'h100 + i, 0, 1, 'h200 + i);
    probe("R8", 'h103, 1, 2, 0);
    probe("R8", 'h104, 1, 1, 'h204);

    // R4: same-cycle lookup sees old state, next cycle sees the fill
    lk_valid = 1; lk_vpn = 'h1F0; lk_write = 0;
    fill_valid = 1; fill_vpn = 'h1F0; fill_pfn = 'h3F0; fill_perm = 3'b011;
    #1 model_check();
    total++;
    if (!lk_miss) begin bad++; $display("FAIL R4: same-cycle hit=%b miss=%b, expected 0 1", lk_hit, lk_miss); end
    advance();
    fill_valid = 0;
    probe("R4", 'h1F0, 0, 1, 'h3F0);
    probe("R7", 'h100, 0, 0, 0);      // slot 0 evicted
    fill('h1F1, 'h3F1, 3'b011);
    probe("R7", 'h101, 0, 0, 0);
    probe("R7", 'h102, 0, 1, 'h202);

    // R5: update in place, pointer untouched
    fill('h105, 'h777, 3'b111);
    probe("R5", 'h105, 1, 1, 'h777);
    fill('h1F2, 'h3F2, 3'b011);
    probe("R5", 'h102, 0, 0, 0);
    probe("R5", 'h105, 0, 1, 'h777);

    // R10, R9
    fill('h1AA, 'h3AA, 3'b011, 1);
    probe("R10", 'h1AA, 0, 0, 0);
    probe("R9", 'h104, 0, 0, 0);
    probe("R9", 'h1F0, 0, 0, 0);

    // R7: pointer back at 0 after flush
    for (int i = 0; i < DEPTH; i++) fill('h400 + i, 'h500 + i, 3'b011);
    fill('h4FF, 'h5FF, 3'b011);
    probe("R7", 'h400, 0, 0, 0);
    probe("R7", 'h401, 0, 1, 'h501);

    // random traffic over a small page range
    for (int n = 0; n < 4000; n++) begin
      lk_valid = ($urandom_range(0, 7) != 0);
      lk_vpn = VPN_W'($urandom_range(0, 31));
      lk_off = OFF_W'($urandom);
      lk_write = $urandom_range(0, 1);
      fill_valid = ($urandom_range(0, 2) == 0);
      fill_vpn = VPN_W'($urandom_range(0, 31));
      fill_pfn = PFN_W'($urandom);
      fill_perm = 3'($urandom);
      flush = ($urandom_range(0, 60) == 0);
      #1 model_check();
      advance();
    end
    lk_valid = 0; fill_valid = 0; flush = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: cycles=%0d, expected completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule